// File: doc/BRIEF.md
# Pattern-Unlocked Serial Register Port

This block sits on a host memory bus between the host and an attached RAM or ROM. Bus cycles are seen one at a time through a chip-select input with output-enable and write-enable qualifiers and a one-bit data path. While locked, every cycle passes through to the memory chip-select output. A write-only sequence of 64 data bits that matches a fixed unlock key opens a window of 64 serial cycles. In that window the attached memory is hidden, and the host reads or writes a 64-bit image of eight 8-bit timekeeping registers, one bit per cycle.

The timekeeping counters lie outside this block. They present their current values on a parallel image input, and they accept whole bytes through a one-cycle write strobe with an index and a data byte. A snapshot of the image is taken at the moment of unlock, so a read-out is coherent. A written byte is passed on only after all eight of its bits have arrived as write cycles. A power-fail input and an external reset pin can abort a window. A mode input selects how the memory chip-select behaves while power is failing. All inputs are taken to be synchronous to `clk`. The reset is synchronous and active high.

Top module: `keyed_serial_port`

## Requirements
- R1: While no window is open and `pwr_fail` is low, `ce_out_n` equals the value `ce_in_n` had one clock earlier.
- R2: The unlock key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C. The key is sent least significant bit first within each byte, starting with the first byte. Write cycle k of an unbroken sequence is compared with key bit k, and a full 64-bit match opens the transfer window.
- R3: A write bit that does not match the key at the current position freezes recognition. All later write cycles are then ignored, and no window opens, until a read cycle restarts recognition.
- R4: A read cycle outside the window returns the comparison position to key bit 0, so any partial match is discarded.
- R5: While the window is open and `pwr_fail` is low, `ce_out_n` is held high.
- R6: In the window, transfer cycle k (k = 0 to 63) refers to image bit k. Bit k is bit k mod 8 of register k div 8, so the order runs from register 0 bit 0 to register 7 bit 7. During a read cycle, `q_oe` is high from one clock after chip select and output enable are both low, and `q_out` carries bit k of the image captured at unlock.
- R7: When the eighth bit of register r arrives in a write cycle, and all eight cycles of that register were write cycles, `wr_en` pulses for one clock with `wr_idx` = r and `wr_data` holding the eight bits, bit 0 first. A register that received any read cycle is not written.
- R8: After the 64th transfer cycle the window closes, recognition restarts at key bit 0, and R1 applies again.
- R9: If `regs_in[36]` (day register 4, bit 4) is 0, a low `rst_pin_n` aborts the window and recognition, and any partly written register is discarded. If that bit is 1, `rst_pin_n` has no effect.
- R10: While `pwr_fail` is high, any window and any recognition in progress are aborted and bus cycles are ignored. In that state `ce_out_n` is forced high when `rom_mode` is 0 and forced low when `rom_mode` is 1, one clock after `pwr_fail` is seen.
- R11: A bus cycle completes on the clock where `ce_in_n` is seen high after being low, using `oe_n`, `we_n` and `d_in` as they were on the clock before. `oe_n` low (with either level of `we_n`) makes a read. `oe_n` high with `we_n` low makes a write. Both high makes no cycle.
- R12: After `rst`, `ce_out_n` is 1, `q_oe` and `wr_en` are 0, and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in_n | input | 1 | Bus chip select, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| d_in | input | 1 | Serial data bit from the host |
| rst_pin_n | input | 1 | External abort request, active low, gated by the reset-disable bit |
| pwr_fail | input | 1 | Supply below threshold |
| rom_mode | input | 1 | 1 selects ROM behaviour of ce_out_n on power fail |
| regs_in | input | 64 | Current image of the eight timekeeping registers |
| ce_out_n | output | 1 | Chip select to the attached memory, active low |
| q_out | output | 1 | Serial data bit to the host |
| q_oe | output | 1 | Drive enable for q_out |
| wr_en | output | 1 | One-clock strobe for a completed register write |
| wr_idx | output | 3 | Register index of the write |
| wr_data | output | 8 | Byte to write |

## Verification
The bench sends a key with one wrong bit and then the remaining correct bits. A design that did not freeze on the mismatch would still unlock. A read cycle part-way through the key tests that recognition restarts. Cycles with no enable, and cycles with both enables low, are inserted to check that the first is ignored and the second aborts as a read. The bench puts a read cycle in the middle of one register during a write window. A design that committed partial registers would emit a strobe for that register. The reset pin is pulled low mid-window with the disable bit both clear and set, and power fail is raised in both memory modes. A wrong abort path shows up either as a window that survives, or as a chip-select level that differs from the per-clock reference model.

// File: rtl/ksp_pkg.sv
package ksp_pkg;
  localparam int unsigned DEF_REG_CNT = 8;
  localparam int unsigned DEF_REG_W   = 8;
  // unlock key, first byte in the low bits, each byte sent lsb first
  localparam logic [63:0] UNLOCK_KEY  = 64'h5CA33AC5_5CA33AC5;

  typedef struct packed {
    logic rd;
    logic wr;
    logic bit_v;
  } bus_ev_t;
endpackage

// File: rtl/ksp_cycle_det.sv
module ksp_cycle_det
  import ksp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ce_in_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    d_in,
  output bus_ev_t ev
);
  logic ce_q, oe_q, we_q, d_q;
  logic done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1;
      oe_q <= 1'b1;
      we_q <= 1'b1;
      d_q  <= 1'b0;
    end else begin
      ce_q <= ce_in_n;
      oe_q <= oe_n;
      we_q <= we_n;
      d_q  <= d_in;
    end
  end

  // cycle completes on deassertion of chip select
  assign done     = !ce_q && ce_in_n;
  assign ev.rd    = done && !oe_q;
  assign ev.wr    = done && oe_q && !we_q;
  assign ev.bit_v = d_q;
endmodule

// File: rtl/ksp_key_match.sv
module ksp_key_match
  import ksp_pkg::*;
#(
  parameter int unsigned KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = UNLOCK_KEY,
  localparam int unsigned PTR_W = $clog2(KEY_W)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    en,
  input  bus_ev_t ev,
  output logic    unlock
);
  logic [PTR_W-1:0] ptr;
  logic             miss;
  logic             hit;
  logic             last;

  assign hit    = (ev.bit_v == KEY[ptr]);
  assign last   = (ptr == PTR_W'(KEY_W - 1));
  assign unlock = en && !clr && ev.wr && !miss && hit && last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr  <= '0;
      miss <= 1'b0;
    end else if (en) begin
      if (ev.rd) begin
        ptr  <= '0;
        miss <= 1'b0;
      end else if (ev.wr && !miss) begin
        if (!hit)       miss <= 1'b1;
        else if (last)  ptr  <= '0;
        else            ptr  <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ksp_xfer.sv
module ksp_xfer
  import ksp_pkg::*;
#(
  parameter int unsigned REG_CNT = DEF_REG_CNT,
  parameter int unsigned REG_W   = DEF_REG_W,
  localparam int unsigned IMG_W  = REG_CNT * REG_W,
  localparam int unsigned PTR_W  = $clog2(IMG_W),
  localparam int unsigned BIT_W  = $clog2(REG_W),
  localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic [IMG_W-1:0] img_in,
  input  bus_ev_t          ev,
  output logic             active,
  output logic             bit_out,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data
);
  logic [IMG_W-1:0] snap;
  logic [PTR_W-1:0] xptr;
  logic [REG_W-1:0] asm_q, asm_nxt;
  logic             all_wr;
  logic [BIT_W-1:0] bi;
  logic             step, last_bit, last_cyc, byte_ok;

  assign bi       = xptr[BIT_W-1:0];
  assign step     = active && (ev.rd || ev.wr);
  assign last_bit = (bi == BIT_W'(REG_W - 1));
  assign last_cyc = (xptr == PTR_W'(IMG_W - 1));
  assign byte_ok  = all_wr && ev.wr;
  assign bit_out  = snap[xptr];

  always_comb begin
    asm_nxt     = asm_q;
    asm_nxt[bi] = ev.bit_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      xptr    <= '0;
      all_wr  <= 1'b1;
      asm_q   <= '0;
      snap    <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        xptr   <= '0;
        all_wr <= 1'b1;
      end else if (start) begin
        active <= 1'b1;
        snap   <= img_in;
        xptr   <= '0;
        all_wr <= 1'b1;
      end else if (step) begin
        if (ev.wr) asm_q <= asm_nxt;
        if (last_bit) begin
          wr_en   <= byte_ok;
          wr_idx  <= xptr[PTR_W-1:BIT_W];
          wr_data <= asm_nxt;
          all_wr  <= 1'b1;
        end else begin
          all_wr  <= byte_ok;
        end
        if (last_cyc) begin
          active <= 1'b0;
          xptr   <= '0;
        end else begin
          xptr   <= xptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port
  import ksp_pkg::*;
#(
  parameter int unsigned REG_CNT = DEF_REG_CNT,
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned DIS_REG = 4,
  parameter int unsigned DIS_BIT = 4,
  localparam int unsigned IMG_W  = REG_CNT * REG_W,
  localparam int unsigned IDX_W  = $clog2(REG_CNT),
  parameter logic [IMG_W-1:0] KEY = IMG_W'(UNLOCK_KEY)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_in_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             d_in,
  input  logic             rst_pin_n,
  input  logic             pwr_fail,
  input  logic             rom_mode,
  input  logic [IMG_W-1:0] regs_in,
  output logic             ce_out_n,
  output logic             q_out,
  output logic             q_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data
);
  localparam int unsigned DIS_POS = DIS_REG * REG_W + DIS_BIT;

  bus_ev_t ev;
  logic    abort, unlock, in_xfer, xbit;

  assign abort = pwr_fail || (!rst_pin_n && !regs_in[DIS_POS]);

  ksp_cycle_det u_det (
    .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .oe_n(oe_n),
    .we_n(we_n), .d_in(d_in), .ev(ev)
  );

  ksp_key_match #(.KEY_W(IMG_W), .KEY(KEY)) u_key (
    .clk(clk), .rst(rst), .clr(abort), .en(!in_xfer),
    .ev(ev), .unlock(unlock)
  );

  ksp_xfer #(.REG_CNT(REG_CNT), .REG_W(REG_W)) u_xfer (
    .clk(clk), .rst(rst), .abort(abort), .start(unlock),
    .img_in(regs_in), .ev(ev), .active(in_xfer), .bit_out(xbit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_out_n <= 1'b1;
      q_oe     <= 1'b0;
      q_out    <= 1'b0;
    end else begin
      if (pwr_fail)     ce_out_n <= !rom_mode;
      else if (in_xfer) ce_out_n <= 1'b1;
      else              ce_out_n <= ce_in_n;
      q_oe  <= in_xfer && !ce_in_n && !oe_n && !pwr_fail;
      q_out <= xbit;
    end
  end
endmodule

// File: rtl/ksp_chk.sv
module ksp_chk (
  input logic clk,
  input logic rst,
  input logic ce_in_n,
  input logic oe_n,
  input logic pwr_fail,
  input logic rom_mode,
  input logic in_xfer,
  input logic ce_out_n,
  input logic q_oe,
  input logic wr_en
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_xfer && !pwr_fail) |=> (ce_out_n == $past(ce_in_n)));

  // R5
  window_hides_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (in_xfer && !pwr_fail) |=> ce_out_n);

  // R10
  pf_ram_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_fail && !rom_mode) |=> ce_out_n);

  // R10
  pf_rom_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_fail && rom_mode) |=> !ce_out_n);

  // R6
  drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    q_oe |-> ($past(!ce_in_n) && $past(!oe_n) && $past(!pwr_fail)));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind keyed_serial_port ksp_chk u_chk (
  .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .oe_n(oe_n),
  .pwr_fail(pwr_fail), .rom_mode(rom_mode), .in_xfer(in_xfer),
  .ce_out_n(ce_out_n), .q_oe(q_oe), .wr_en(wr_en)
);

// File: tb/keyed_serial_port_test.sv
module keyed_serial_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_in_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d_in = 1'b0;
  logic rst_pin_n = 1'b1, pwr_fail = 1'b0, rom_mode = 1'b0;
  logic [63:0] regs_in = 64'h0;
  logic ce_out_n, q_out, q_oe, wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;

  int tests = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  keyed_serial_port uut (
    .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .oe_n(oe_n), .we_n(we_n),
    .d_in(d_in), .rst_pin_n(rst_pin_n), .pwr_fail(pwr_fail),
    .rom_mode(rom_mode), .regs_in(regs_in), .ce_out_n(ce_out_n),
    .q_out(q_out), .q_oe(q_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data)
  );

  byte unsigned kbytes [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};
  function automatic logic kbit(int i);
    return kbytes[i / 8][i % 8];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  bit m_cq = 1, m_oq = 1, m_wq = 1, m_dq = 0;
  int m_kpos = 0, m_xpos = 0;
  bit m_miss = 0, m_open = 0, m_allw = 1, m_ready = 0;
  bit [63:0] m_snap = 0;
  bit [7:0] m_byte = 0;
  bit e_ce = 1, e_qoe = 0, e_q = 0, e_wen = 0;
  int e_widx = 0;
  bit [7:0] e_wdat = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cq = 1; m_oq = 1; m_wq = 1; m_dq = 0;
      m_kpos = 0; m_xpos = 0; m_miss = 0; m_open = 0; m_allw = 1;
      e_ce = 1; e_qoe = 0; e_q = 0; e_wen = 0; m_ready = 1;
    end else begin
      bit done, rd, wr, ab;
      done = !m_cq && ce_in_n;
      rd = done && !m_oq;
      wr = done && m_oq && !m_wq;
      ab = pwr_fail || (!rst_pin_n && !regs_in[36]);
      e_ce  = pwr_fail ? !rom_mode : (m_open ? 1'b1 : ce_in_n);
      e_qoe = m_open && !ce_in_n && !oe_n && !pwr_fail;
      e_q   = m_snap[m_xpos];
      e_wen = 0;
      if (ab) begin
        m_open = 0; m_xpos = 0; m_allw = 1; m_kpos = 0; m_miss = 0;
      end else if (m_open) begin
        if (rd || wr) begin
          if (wr) m_byte[m_xpos % 8] = m_dq;
          if (rd) m_allw = 0;
          if (m_xpos % 8 == 7) begin
            e_wen = m_allw; e_widx = m_xpos / 8; e_wdat = m_byte; m_allw = 1;
          end
          m_xpos++;
          if (m_xpos == 64) begin m_open = 0; m_xpos = 0; end
        end
      end else if (rd) begin
        m_kpos = 0; m_miss = 0;
      end else if (wr && !m_miss) begin
        if (m_dq != kbit(m_kpos)) m_miss = 1;
        else if (m_kpos == 63) begin
          m_kpos = 0; m_open = 1; m_snap = regs_in; m_xpos = 0; m_allw = 1;
        end else m_kpos++;
      end
      m_cq = ce_in_n; m_oq = oe_n; m_wq = we_n; m_dq = d_in;
    end
  end

  // per-clock comparison and write-strobe log
  logic [10:0] wlog [$];
  always @(negedge clk) begin
    if (!rst && m_ready) begin
      check("R1 R5 R10 ce_out_n", 64'(ce_out_n), 64'(e_ce));
      check("R6 q_oe", 64'(q_oe), 64'(e_qoe));
      if (e_qoe) check("R6 q_out", 64'(q_out), 64'(e_q));
      check("R7 wr_en", 64'(wr_en), 64'(e_wen));
      if (e_wen) check("R7 wr_idx/wr_data", {53'b0, wr_idx, wr_data}, {53'b0, 3'(e_widx), e_wdat});
    end
    if (!rst && wr_en) wlog.push_back({wr_idx, wr_data});
  end

  // kind: 0 read, 1 write, 2 no enable, 3 both enables
  logic s_qoe, s_q, s_ce;
  task automatic cyc(int kind, logic b);
    ce_in_n = 0;
    oe_n = !(kind == 0 || kind == 3);
    we_n = !(kind == 1 || kind == 3);
    d_in = b;
    @(negedge clk); @(negedge clk);
    s_qoe = q_oe; s_q = q_out; s_ce = ce_out_n;
    ce_in_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_key(int bad_at);
    for (int i = 0; i < 64; i++) cyc(1, kbit(i) ^ (i == bad_at));
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] got;
    regs_in = 64'hA55A_3C96_0F1E_5AB7;
    regs_in[36] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12 ce_out_n", 64'(ce_out_n), 64'd1);
    check("R12 q_oe", 64'(q_oe), 64'd0);
    check("R12 wr_en", 64'(wr_en), 64'd0);

    // R1 pass-through before unlock
    cyc(0, 0);
    check("R1 ce_out_n low in locked read", 64'(s_ce), 64'd0);
    check("R1 no q drive", 64'(s_qoe), 64'd0);

    // R2 R6 R5 R8: unlock and read out the full image
    cyc(0, 0);
    send_key(-1);
    got = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(0, 0);
      got[i] = s_q;
      if (i == 5) check("R5 ce_out_n high in window", 64'(s_ce), 64'd1);
      if (i == 5) check("R2 window open q_oe", 64'(s_qoe), 64'd1);
    end
    check("R6 read-out order", got, regs_in);
    cyc(0, 0);
    check("R8 window closed q_oe", 64'(s_qoe), 64'd0);
    check("R8 pass-through again", 64'(s_ce), 64'd0);

    // R3 mismatch freezes, correct rest ignored
    send_key(10);
    cyc(0, 0);
    check("R3 no unlock after bad bit", 64'(s_qoe), 64'd0);

    // R4 read mid-key restarts; R11 idle cycles ignored
    for (int i = 0; i < 20; i++) cyc(1, kbit(i));
    cyc(0, 0);
    for (int i = 0; i < 64; i++) begin
      cyc(1, kbit(i));
      if (i == 30) cyc(2, 0);
    end
    cyc(0, 0);
    check("R4 R11 unlock after restart", 64'(s_qoe), 64'd1);
    for (int i = 1; i < 64; i++) cyc(0, 0);

    // R11 both enables low counts as a read and restarts the key
    for (int i = 0; i < 40; i++) cyc(1, kbit(i));
    cyc(3, 0);
    for (int i = 40; i < 64; i++) cyc(1, kbit(i));
    cyc(0, 0);
    check("R11 both-low treated as read", 64'(s_qoe), 64'd0);

    // R7 write window with a read inside register 2
    wlog.delete();
    cyc(0, 0);
    send_key(-1);
    for (int i = 0; i < 64; i++) begin
      if (i == 19) cyc(0, 0);
      else cyc(1, (64'hDEAD_BEEF_1234_5678 >> i) & 1);
    end
    check("R7 commit count", 64'(wlog.size()), 64'd7);
    if (wlog.size() == 7) begin
      check("R7 first byte", 64'(wlog[0]), {53'b0, 3'd0, 8'h78});
      check("R7 reg2 skipped", 64'(wlog[2][10:8]), 64'd3);
      check("R7 last byte", 64'(wlog[6]), {53'b0, 3'd7, 8'hDE});
    end

    // R9 reset pin ignored when disable bit set
    wlog.delete();
    cyc(0, 0);
    send_key(-1);
    for (int i = 0; i < 64; i++) begin
      if (i == 20) begin rst_pin_n = 0; @(negedge clk); rst_pin_n = 1; end
      cyc(1, i[0]);
    end
    check("R9 pin ignored, all commits", 64'(wlog.size()), 64'd8);

    // R9 reset pin aborts when disable bit clear
    wlog.delete();
    regs_in[36] = 1'b0;
    cyc(0, 0);
    send_key(-1);
    for (int i = 0; i < 20; i++) cyc(1, 1);
    rst_pin_n = 0; @(negedge clk); rst_pin_n = 1;
    cyc(0, 0);
    check("R9 abort ends window", 64'(s_qoe), 64'd0);
    check("R9 partial byte dropped", 64'(wlog.size()), 64'd2);
    regs_in[36] = 1'b1;

    // R10 power fail, RAM then ROM mode
    cyc(0, 0);
    send_key(-1);
    cyc(0, 0);
    pwr_fail = 1;
    cyc(0, 0);
    check("R10 RAM ce_out_n high", 64'(s_ce), 64'd1);
    check("R10 no drive in power fail", 64'(s_qoe), 64'd0);
    rom_mode = 1;
    send_key(-1);
    cyc(0, 0);
    check("R10 ROM ce_out_n low", 64'(s_ce), 64'd0);
    pwr_fail = 0; rom_mode = 0;
    cyc(0, 0);
    check("R10 key ignored during power fail", 64'(s_qoe), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule